// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a set of general-purpose input pads and turns activity on them into interrupt requests. Each pad is resynchronised into the core clock domain, then compared against the detection mode chosen for that pin: active-high or active-low level, rising edge, falling edge, or both edges. A hit sets a sticky status bit. An interrupt enable decides whether that status reaches an interrupt line. A target field picks which of several processor interrupt lines the pin drives.

Software reaches the block through a small flat register port. There are two byte-wide registers per pin: a configuration register and a status register. Status capture has its own arming bit, separate from the interrupt enable. Once a pin has been armed and cleared during setup, masking and unmasking change only the enable bit and never create a spurious event. Status is cleared by writing a zero. Each interrupt output is the registered OR of every pin routed to that target whose status and enable are both set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0xE2 (target 7, arming off, level mode, polarity high, enable off), every status reads 0 and every interrupt output is low.
- R2: Register address is {pin index, select}: select 0 is the configuration register and select 1 is the status register. The configuration layout is bit 0 enable, bit 1 polarity, bits 3:2 detection type, bit 4 arming, bits 7:5 target. A configuration write stores all eight bits and changes no other pin.
- R3: The status register holds the flag in bit 0, and bits 7:1 always read 0. Writing with data bit 0 clear clears the flag. Writing with data bit 0 set leaves it unchanged.
- R4: While the arming bit (bit 4) is clear, no input activity sets the status flag.
- R5: Detection type 00 is level mode: polarity 1 latches while the synchronised input is high, polarity 0 while it is low. A clear issued while the active level is still present leaves the flag set.
- R6: Detection type 01 with polarity 1 latches on a rising edge and with polarity 0 on a falling edge. Type 10 latches on a falling edge only. Type 11 latches on either edge.
- R7: While disarmed, the edge history is held at the opposite of the input. Arming a pin whose pad already sits at the level that follows its selected edge therefore latches the flag immediately.
- R8: The enable bit only gates the flag onto the interrupt output. Setting or clearing it leaves the status flag unchanged.
- R9: Interrupt output t is high when at least one pin has its flag set, its enable set and its target field equal to t. Target values at or above the number of outputs drive nothing.
- R10: The pad passes two synchronising flops. The status flag is set on the third rising clock edge after the pad change, and the interrupt output follows one edge after the flag.
- R11: When a detection and a status-clear write for the same pin land on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | N | Asynchronous pad inputs, one per pin |
| reg_addr | input | AW | Register address {pin index, select} |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_out | output | NUM_TGT | One registered interrupt line per target |

## Verification
Errors in the edge history are the most likely to go unnoticed. A history register that does not track while armed, or that is not inverted while disarmed, shows up as a status flag missing or appearing spuriously three edges after a pad change. It also shows up at the instant a pin is armed. A status flag that enable writes disturb, or that a same-cycle clear overrides, reads back wrong on the very next register read. Routing errors appear on the interrupt lines one edge after the flag, so the bench samples each latency stage separately.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W = 8;
    localparam int TGT_W = 3;
    localparam logic [CFG_W-1:0] CFG_RST = 8'hE2;

    typedef enum logic [1:0] {
        DET_LEVEL    = 2'b00,
        DET_EDGE_POL = 2'b01,
        DET_FALL     = 2'b10,
        DET_BOTH     = 2'b11
    } det_e;

    typedef enum logic {
        SEL_CFG = 1'b0,
        SEL_STS = 1'b1
    } reg_sel_e;

    // Packed MSB first: tgt[7:5] arm[4] det[3:2] pol[1] en[0]
    typedef struct packed {
        logic [TGT_W-1:0] tgt;
        logic             arm;
        det_e             det;
        logic             pol;
        logic             en;
    } pin_cfg_t;

    function automatic logic det_hit(input pin_cfg_t c, input logic cur, input logic prv);
        logic rise, fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        unique case (c.det)
            DET_LEVEL:    return c.pol ? cur : ~cur;
            DET_EDGE_POL: return c.pol ? rise : fall;
            DET_FALL:     return fall;
            DET_BOTH:     return rise | fall;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pad_s,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sts_clr,
    output pin_cfg_t         cfg_o,
    output logic             sts_o,
    output logic             req_o
);
    pin_cfg_t cfg_q;
    logic     prev_q;
    logic     sts_q;
    logic     hit;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= pin_cfg_t'(CFG_RST);
        else if (cfg_we) cfg_q <= pin_cfg_t'(cfg_wdata);
    end

    // Edge history: follows the input while armed, held inverted while
    // disarmed, so that arming sees whatever edge the pad level implies.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cfg_q.arm ? pad_s : ~pad_s;
    end

    assign hit = cfg_q.arm & det_hit(cfg_q, pad_s, prev_q);

    // Detection takes priority over a software clear.
    always_ff @(posedge clk) begin
        if (rst)          sts_q <= 1'b0;
        else if (hit)     sts_q <= 1'b1;
        else if (sts_clr) sts_q <= 1'b0;
    end

    assign cfg_o = cfg_q;
    assign sts_o = sts_q;
    assign req_o = sts_q & cfg_q.en;
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int N       = 4,
    parameter int NUM_TGT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic [N*TGT_W-1:0]   tgt_flat,
    output logic [NUM_TGT-1:0]   irq
);
    logic [NUM_TGT-1:0] any_hit;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        always_comb begin
            any_hit[t] = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (req[i] && tgt_flat[i*TGT_W +: TGT_W] == TGT_W'(t))
                    any_hit[t] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= '0;
        else     irq <= any_hit;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N       = 4,
    parameter int NUM_TGT = 4,
    parameter int SYNC_N  = 2,
    parameter int PIN_W   = (N > 1) ? $clog2(N) : 1,
    parameter int AW      = PIN_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       pad_in,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [NUM_TGT-1:0] irq_out
);
    logic [N-1:0]       pad_s;
    pin_cfg_t           cfg_arr [N];
    logic [N-1:0]       sts_vec;
    logic [N-1:0]       en_vec;
    logic [N-1:0]       arm_vec;
    logic [N-1:0]       req_vec;
    logic [N*TGT_W-1:0] tgt_flat;
    logic [PIN_W-1:0]   a_pin;
    reg_sel_e           a_sel;

    assign a_pin = reg_addr[AW-1:1];
    assign a_sel = reg_sel_e'(reg_addr[0]);

    gpio_irq_sync #(.W(N), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_s)
    );

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic hit_pin;
        assign hit_pin = reg_wr && (a_pin == PIN_W'(i));

        gpio_irq_pin u_pin (
            .clk       (clk),
            .rst       (rst),
            .pad_s     (pad_s[i]),
            .cfg_we    (hit_pin && a_sel == SEL_CFG),
            .cfg_wdata (reg_wdata),
            .sts_clr   (hit_pin && a_sel == SEL_STS && !reg_wdata[0]),
            .cfg_o     (cfg_arr[i]),
            .sts_o     (sts_vec[i]),
            .req_o     (req_vec[i])
        );

        assign en_vec[i]                     = cfg_arr[i].en;
        assign arm_vec[i]                    = cfg_arr[i].arm;
        assign tgt_flat[i*TGT_W +: TGT_W]    = cfg_arr[i].tgt;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (a_pin == PIN_W'(i))
                reg_rdata = (a_sel == SEL_STS) ? {7'b0, sts_vec[i]} : 8'(cfg_arr[i]);
        end
    end

    gpio_irq_route #(.N(N), .NUM_TGT(NUM_TGT)) u_route (
        .clk      (clk),
        .rst      (rst),
        .req      (req_vec),
        .tgt_flat (tgt_flat),
        .irq      (irq_out)
    );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int N       = 4,
    parameter int NUM_TGT = 4,
    parameter int AW      = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [AW-1:0]      reg_addr,
    input logic               reg_wr,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic [NUM_TGT-1:0] irq_out,
    input logic [N-1:0]       sts_vec,
    input logic [N-1:0]       en_vec,
    input logic [N-1:0]       arm_vec
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sts_vec == '0 && irq_out == '0));

    // R3
    sts_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_addr[0] |-> reg_rdata[7:1] == 7'b0);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(sts_vec & en_vec)) |=> irq_out == '0);

    for (genvar i = 0; i < N; i++) begin : g_pin_chk
        logic clr_wr;
        assign clr_wr = reg_wr && reg_addr == AW'((i << 1) | 1) && !reg_wdata[0];

        // R4
        disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!arm_vec[i] && !sts_vec[i]) |=> !sts_vec[i]);

        // R8
        sts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (sts_vec[i] && !clr_wr) |=> sts_vec[i]);
    end
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N(N), .NUM_TGT(NUM_TGT), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .sts_vec   (sts_vec),
    .en_vec    (en_vec),
    .arm_vec   (arm_vec)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int N = 4;
    localparam int NT = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pad_in = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NT-1:0] irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.N(N), .NUM_TGT(NT)) u0 (
        .clk(clk), .rst(rst), .pad_in(pad_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [7:0] cfgv(input int tgt, input bit arm,
                                        input logic [1:0] det, input bit pol, input bit en);
        return {3'(tgt), arm, det, pol, en};
    endfunction

    function automatic logic [AW-1:0] ad(input int pin, input bit sel);
        return {2'(pin), sel};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sts_is(input int pin, input bit exp, input string req);
        logic [7:0] d;
        rd(ad(pin, 1), d);
        chk(d == {7'b0, exp}, req, d, {7'b0, exp});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int p = 0; p < N; p++) begin
            rd(ad(p, 0), d); chk(d == 8'hE2, "R1 cfg", d, 8'hE2);
            rd(ad(p, 1), d); chk(d == 8'h00, "R1 sts", d, 0);
        end
        chk(irq_out == '0, "R1 irq", irq_out, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(ad(0, 0), 8'h4B);
        rd(ad(0, 0), d); chk(d == 8'h4B, "R2 readback", d, 8'h4B);
        rd(ad(1, 0), d); chk(d == 8'hE2, "R2 other pin", d, 8'hE2);
        wr(ad(0, 0), 8'hE2);
        wr(ad(0, 1), 8'h00);
    endtask

    task automatic t_arm_gate();
        pad_in[1] = 1'b1;
        wr(ad(1, 0), cfgv(0, 0, 2'b00, 1, 0));
        wait_n(5);
        pad_in[1] = 1'b0; wait_n(4); pad_in[1] = 1'b1; wait_n(4);
        sts_is(1, 0, "R4 disarmed");
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(ad(1, 0), cfgv(0, 1, 2'b00, 1, 0));
        wait_n(2);
        sts_is(1, 1, "R5 level high");
        wr(ad(1, 1), 8'h00);
        sts_is(1, 1, "R5 clear under active level");
        wr(ad(1, 1), 8'h01);
        rd(ad(1, 1), d); chk(d == 8'h01, "R3 write one keeps, upper zero", d, 1);
        pad_in[1] = 1'b0; wait_n(4);
        wr(ad(1, 1), 8'hFE);
        sts_is(1, 0, "R3 write zero clears");
        wr(ad(1, 1), 8'hFF);
        sts_is(1, 0, "R3 write one does not set");
        wr(ad(1, 0), cfgv(0, 1, 2'b00, 0, 0));
        wait_n(2);
        sts_is(1, 1, "R5 level low");
        wr(ad(1, 0), cfgv(0, 0, 2'b00, 1, 0));
        wr(ad(1, 1), 8'h00);
    endtask

    task automatic edge_case(input logic [1:0] det, input bit pol, input bit from,
                             input bit to, input bit exp, input string req);
        pad_in[2] = from; wait_n(4);
        wr(ad(2, 0), cfgv(0, 1, det, pol, 0));
        wait_n(3);
        wr(ad(2, 1), 8'h00);
        wait_n(1);
        pad_in[2] = to; wait_n(5);
        sts_is(2, exp, req);
        wr(ad(2, 0), cfgv(0, 0, 2'b00, 1, 0));
        wr(ad(2, 1), 8'h00);
    endtask

    task automatic t_edges();
        edge_case(2'b01, 1, 0, 1, 1, "R6 type01 pol1 rise");
        edge_case(2'b01, 1, 1, 0, 0, "R6 type01 pol1 fall ignored");
        edge_case(2'b01, 0, 1, 0, 1, "R6 type01 pol0 fall");
        edge_case(2'b10, 1, 0, 1, 0, "R6 type10 rise ignored");
        edge_case(2'b10, 1, 1, 0, 1, "R6 type10 fall");
        edge_case(2'b11, 1, 0, 1, 1, "R6 type11 rise");
        edge_case(2'b11, 1, 1, 0, 1, "R6 type11 fall");
    endtask

    task automatic t_arming();
        pad_in[3] = 1'b1; wait_n(4);
        wr(ad(3, 0), cfgv(2, 0, 2'b01, 1, 0));
        wait_n(2);
        sts_is(3, 0, "R7 before arm");
        wr(ad(3, 0), cfgv(2, 1, 2'b01, 1, 0));
        wait_n(1);
        sts_is(3, 1, "R7 arm rising with pad high");
        wr(ad(3, 0), cfgv(2, 0, 2'b10, 1, 0));
        pad_in[3] = 1'b0; wait_n(4);
        wr(ad(3, 1), 8'h00);
        sts_is(3, 0, "R7 cleared");
        wr(ad(3, 0), cfgv(2, 1, 2'b10, 1, 0));
        wait_n(1);
        sts_is(3, 1, "R7 arm falling with pad low");
    endtask

    task automatic t_enable();
        wait_n(2);
        chk(irq_out == 4'b0000, "R8 masked", irq_out, 0);
        wr(ad(3, 0), cfgv(2, 1, 2'b10, 1, 1));
        wait_n(1);
        chk(irq_out == 4'b0100, "R8 unmask", irq_out, 4'b0100);
        sts_is(3, 1, "R8 status after unmask");
        wr(ad(3, 0), cfgv(2, 1, 2'b10, 1, 0));
        wait_n(1);
        chk(irq_out == 4'b0000, "R8 remask", irq_out, 0);
        sts_is(3, 1, "R8 status after remask");
    endtask

    task automatic t_route();
        pad_in[0] = 1'b1; pad_in[1] = 1'b1; pad_in[2] = 1'b1;
        wait_n(4);
        wr(ad(0, 0), cfgv(1, 1, 2'b00, 1, 1));
        wr(ad(1, 0), cfgv(1, 1, 2'b00, 1, 1));
        wr(ad(2, 0), cfgv(3, 1, 2'b00, 1, 1));
        wr(ad(3, 0), cfgv(7, 1, 2'b10, 1, 1));
        wait_n(2);
        chk(irq_out == 4'b1010, "R9 routing", irq_out, 4'b1010);
        pad_in[0] = 1'b0; wait_n(4); wr(ad(0, 1), 8'h00); wait_n(1);
        chk(irq_out == 4'b1010, "R9 shared target held", irq_out, 4'b1010);
        pad_in[1] = 1'b0; wait_n(4); wr(ad(1, 1), 8'h00); wait_n(1);
        chk(irq_out == 4'b1000, "R9 shared target drops", irq_out, 4'b1000);
        pad_in[2] = 1'b0; wait_n(4); wr(ad(2, 1), 8'h00); wait_n(1);
        chk(irq_out == 4'b0000, "R9 target 7 drives nothing", irq_out, 0);
    endtask

    task automatic t_latency();
        wr(ad(0, 0), cfgv(0, 1, 2'b01, 1, 1));
        wait_n(3);
        wr(ad(0, 1), 8'h00);
        wait_n(1);
        pad_in[0] = 1'b1;
        @(negedge clk); sts_is(0, 0, "R10 edge 1");
        @(negedge clk); sts_is(0, 0, "R10 edge 2");
        @(negedge clk); sts_is(0, 1, "R10 edge 3");
        chk(irq_out[0] == 1'b0, "R10 irq not yet", irq_out, 0);
        @(negedge clk);
        chk(irq_out[0] == 1'b1, "R10 irq one later", irq_out, 1);
    endtask

    task automatic t_setwins();
        pad_in[0] = 1'b0; wait_n(4);
        wr(ad(0, 1), 8'h00);
        sts_is(0, 0, "R11 precondition");
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = ad(0, 1); reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        sts_is(0, 1, "R11 set beats clear");
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_regs();
        t_arm_gate();
        t_level();
        t_edges();
        t_arming();
        t_enable();
        t_route();
        t_latency();
        t_setwins();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule